// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible control and status bank of a simple LCD panel controller. A 32-bit word bus writes and reads six registers: a control word, three panel timing words, a status word and a subpanel word. The control word is split into separate fields: palette loading mode, active-matrix (TFT) select, two interrupt enables, monochrome select and controller enable. Width and height are stored as minus-one codes, so a cleared register stands for a one-pixel dimension. Readback forces fixed patterns into reserved bits and shows the TFT bit in two positions.

The pixel engine, which is outside this block, reports three events as single-cycle pulses: frame done, palette loaded and sync error. Each event sets a sticky status flag. The flags feed one interrupt output through the enables held in the control word. A sync error is never masked. Turning the controller off through a control write clears all three flags. Any write that flips the enable bit produces a one-cycle update request toward the engine. Register writes take effect at the clock edge. Reads are combinational from the address.

Top module: `lcdreg_top`

## Requirements
- R1: Word registers decode at byte offsets 0x00 control, 0x04 timing 0, 0x08 timing 1, 0x0C timing 2, 0x10 status and 0x14 subpanel. Any other address reads as zero, and a write to it changes nothing.
- R2: A control write stores palette mode from bits 21:20, TFT from bit 7, interrupt enables from bits 4:3 (bit 3 = frame-done enable, bit 4 = palette-done enable), mono from bit 1 and enable from bit 0. The rest of the word is kept under mask 0x01CFF300. Readback is TFT at bits 23 and 7, mode at 21:20, enables at 4:3, mono at 1, enable at 0, the kept bits, all ORed with 0xFE000C34.
- R3: Timing 0 keeps width minus one in bits 9:0 (also driven on `width_m1`) and bits 31:10 as a timing field. It reads back the stored word ORed with 0x0000000F.
- R4: Timing 1 keeps height minus one in bits 9:0 (driven on `height_m1`) and bits 31:10 verbatim, and reads back unchanged. Timing 2 keeps the full word and reads it ORed with 0xFC000000.
- R5: A subpanel write stores the word ANDed with 0xA1FFFFFF, and the register reads back that stored value.
- R6: Status reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. Each flag is set on the edge that samples its event pulse and stays set. Writes to status have no effect.
- R7: `irq` is high when frame-done is set with enable bit 3, when palette-done is set with enable bit 4, or whenever sync-error is set. Otherwise it is low.
- R8: A control write that changes the enable bit makes `update_req` high for exactly the following cycle. A control write that leaves the enable bit unchanged produces no pulse.
- R9: A control write that moves enable from 1 to 0 clears all status flags. An event sampled on that same edge still sets its flag. A write of enable 0 while already 0 does not clear.
- R10: Synchronous reset clears every register. Control then reads 0xFE000C34, timing 0 reads 0x0000000F, timing 2 reads 0xFC000000, `width_m1` and `height_m1` are 0, and `irq` and `update_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ev_frame_done | input | 1 | Frame-done event pulse from the engine |
| ev_palette_done | input | 1 | Palette-loaded event pulse |
| ev_sync_error | input | 1 | Sync-error event pulse |
| irq | output | 1 | Combined interrupt |
| update_req | output | 1 | One-cycle pulse on an enable change |
| enable_o | output | 1 | Controller enable |
| pal_mode_o | output | 2 | Palette loading mode |
| tft_o | output | 1 | Active-matrix select |
| mono_o | output | 1 | Monochrome select |
| width_m1 | output | DIM_W | Panel width minus one |
| height_m1 | output | DIM_W | Panel height minus one |

## Verification
Two functions can meet on one clock edge: the flag clear caused by a disabling control write, and the flag set caused by an engine event. The bench collides them by writing enable to 0 while a palette-done pulse is present. It then expects the old frame-done and sync-error flags to be gone, the palette-done flag to be set, and an update pulse. The case of writing 0 when the enable is already 0 is also driven, to show that the clear is tied to the 1-to-0 transition and not to the written value.

// File: rtl/lcdreg_pkg.sv
package lcdreg_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W_D = 8;
    localparam int DIM_W_D  = 10;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] CTRL_RD_FORCE  = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] TIM0_RD_FORCE  = 32'h0000_000F;
    localparam logic [DATA_W-1:0] TIM2_RD_FORCE  = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUBP_WR_MASK   = 32'hA1FF_FFFF;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_TIM0 = 'h04;
    localparam int OFS_TIM1 = 'h08;
    localparam int OFS_TIM2 = 'h0C;
    localparam int OFS_STAT = 'h10;
    localparam int OFS_SUBP = 'h14;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_TIM0,
        SEL_TIM1,
        SEL_TIM2,
        SEL_STAT,
        SEL_SUBP,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]        pal_mode;
        logic              tft;
        logic [1:0]        irq_en;
        logic              mono;
        logic              enable;
        logic [DATA_W-1:0] kept;
    } ctrl_t;

    typedef struct packed {
        logic pal_done;
        logic sync_err;
        logic frame_done;
    } flags_t;

    function automatic reg_sel_e decode_sel(input logic [DATA_W-1:0] a);
        case (a)
            OFS_CTRL: return SEL_CTRL;
            OFS_TIM0: return SEL_TIM0;
            OFS_TIM1: return SEL_TIM1;
            OFS_TIM2: return SEL_TIM2;
            OFS_STAT: return SEL_STAT;
            OFS_SUBP: return SEL_SUBP;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.pal_mode = w[21:20];
        c.tft      = w[7];
        c.irq_en   = w[4:3];
        c.mono     = w[1];
        c.enable   = w[0];
        c.kept     = w & CTRL_KEEP_MASK;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = c.kept | CTRL_RD_FORCE;
        w[23]    = w[23] | c.tft;
        w[21:20] = w[21:20] | c.pal_mode;
        w[7]     = w[7] | c.tft;
        w[4:3]   = w[4:3] | c.irq_en;
        w[1]     = w[1] | c.mono;
        w[0]     = w[0] | c.enable;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] flags_to_word(input flags_t f);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[6] = f.pal_done;
        w[2] = f.sync_err;
        w[0] = f.frame_done;
        return w;
    endfunction

endpackage

// File: rtl/lcdreg_ctrl.sv
module lcdreg_ctrl
    import lcdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              update_req,
    output logic              en_fall
);
    ctrl_t ctrl_next;
    logic  en_change;

    always_comb begin
        ctrl_next = ctrl_from_word(wdata);
        en_change = wr_ctrl && (ctrl_next.enable != ctrl_q.enable);
        en_fall   = en_change && ctrl_q.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            update_req <= 1'b0;
        end else begin
            update_req <= en_change;
            if (wr_ctrl) begin
                ctrl_q <= ctrl_next;
            end
        end
    end
endmodule

// File: rtl/lcdreg_timing.sv
module lcdreg_timing
    import lcdreg_pkg::*;
#(
    parameter int DIM_W = DIM_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_dim,
    input  logic              wr_tim2,
    input  logic              wr_subp,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tim0_rd,
    output logic [DATA_W-1:0] tim1_rd,
    output logic [DATA_W-1:0] tim2_rd,
    output logic [DATA_W-1:0] subp_rd,
    output logic [DIM_W-1:0]  width_m1,
    output logic [DIM_W-1:0]  height_m1
);
    localparam int FIELD_W = DATA_W - DIM_W;

    logic [FIELD_W-1:0] field_q [2];
    logic [DIM_W-1:0]   dim_q   [2];
    logic [DATA_W-1:0]  tim2_q;
    logic [DATA_W-1:0]  subp_q;

    for (genvar g = 0; g < 2; g++) begin : g_dim
        always_ff @(posedge clk) begin
            if (rst) begin
                field_q[g] <= '0;
                dim_q[g]   <= '0;
            end else if (wr_dim[g]) begin
                field_q[g] <= wdata[DATA_W-1:DIM_W];
                dim_q[g]   <= wdata[DIM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tim2_q <= '0;
            subp_q <= '0;
        end else begin
            if (wr_tim2) tim2_q <= wdata;
            if (wr_subp) subp_q <= wdata & SUBP_WR_MASK;
        end
    end

    always_comb begin
        tim0_rd   = {field_q[0], dim_q[0]} | TIM0_RD_FORCE;
        tim1_rd   = {field_q[1], dim_q[1]};
        tim2_rd   = tim2_q | TIM2_RD_FORCE;
        subp_rd   = subp_q;
        width_m1  = dim_q[0];
        height_m1 = dim_q[1];
    end
endmodule

// File: rtl/lcdreg_status.sv
module lcdreg_status
    import lcdreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ev_frame_done,
    input  logic       ev_palette_done,
    input  logic       ev_sync_error,
    input  logic [1:0] irq_en,
    output flags_t     flags_q,
    output logic       irq
);
    flags_t base;

    always_comb begin
        base = clr ? '0 : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.frame_done <= base.frame_done | ev_frame_done;
            flags_q.pal_done   <= base.pal_done   | ev_palette_done;
            flags_q.sync_err   <= base.sync_err   | ev_sync_error;
        end
    end

    always_comb begin
        irq = (flags_q.frame_done & irq_en[0])
            | (flags_q.pal_done   & irq_en[1])
            |  flags_q.sync_err;
    end
endmodule

// File: rtl/lcdreg_top.sv
module lcdreg_top
    import lcdreg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D,
    parameter int DIM_W  = DIM_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ev_frame_done,
    input  logic              ev_palette_done,
    input  logic              ev_sync_error,
    output logic              irq,
    output logic              update_req,
    output logic              enable_o,
    output logic [1:0]        pal_mode_o,
    output logic              tft_o,
    output logic              mono_o,
    output logic [DIM_W-1:0]  width_m1,
    output logic [DIM_W-1:0]  height_m1
);
    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    flags_t            flags_q;
    logic              en_fall;
    logic [DATA_W-1:0] tim0_rd, tim1_rd, tim2_rd, subp_rd;

    always_comb begin
        sel = decode_sel(DATA_W'(addr));
    end

    lcdreg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_en && sel == SEL_CTRL),
        .wdata      (wdata),
        .ctrl_q     (ctrl_q),
        .update_req (update_req),
        .en_fall    (en_fall)
    );

    lcdreg_timing #(.DIM_W(DIM_W)) u_timing (
        .clk       (clk),
        .rst       (rst),
        .wr_dim    ({wr_en && sel == SEL_TIM1, wr_en && sel == SEL_TIM0}),
        .wr_tim2   (wr_en && sel == SEL_TIM2),
        .wr_subp   (wr_en && sel == SEL_SUBP),
        .wdata     (wdata),
        .tim0_rd   (tim0_rd),
        .tim1_rd   (tim1_rd),
        .tim2_rd   (tim2_rd),
        .subp_rd   (subp_rd),
        .width_m1  (width_m1),
        .height_m1 (height_m1)
    );

    lcdreg_status u_status (
        .clk             (clk),
        .rst             (rst),
        .clr             (en_fall),
        .ev_frame_done   (ev_frame_done),
        .ev_palette_done (ev_palette_done),
        .ev_sync_error   (ev_sync_error),
        .irq_en          (ctrl_q.irq_en),
        .flags_q         (flags_q),
        .irq             (irq)
    );

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = ctrl_to_word(ctrl_q);
            SEL_TIM0: rdata = tim0_rd;
            SEL_TIM1: rdata = tim1_rd;
            SEL_TIM2: rdata = tim2_rd;
            SEL_STAT: rdata = flags_to_word(flags_q);
            SEL_SUBP: rdata = subp_rd;
            default:  rdata = '0;
        endcase
        enable_o   = ctrl_q.enable;
        pal_mode_o = ctrl_q.pal_mode;
        tft_o      = ctrl_q.tft;
        mono_o     = ctrl_q.mono;
    end
endmodule

// File: rtl/lcdreg_chk.sv
module lcdreg_chk #(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              ev_frame_done,
    input logic              ev_palette_done,
    input logic              ev_sync_error,
    input logic              irq,
    input logic              update_req,
    input logic              enable_o,
    input logic [DIM_W-1:0]  width_m1,
    input logic [2:0]        flags
);
    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && update_req |-> enable_o != $past(enable_o)); // R8
    AST_CHANGE_MEANS_UPD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && enable_o != $past(enable_o) |-> update_req); // R8
    AST_SYNC_FORCES_IRQ: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ev_sync_error) |-> irq); // R7
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        flags == 3'b000 |-> !irq); // R7
    AST_FRAME_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ev_frame_done) |-> flags[0]); // R6
    AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_en && addr == ADDR_W'('h10) && !ev_frame_done
              && !ev_palette_done && !ev_sync_error) |-> flags == $past(flags)); // R6
    AST_WIDTH_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_en && addr == ADDR_W'('h04)) |-> width_m1 == $past(wdata[DIM_W-1:0])); // R3
endmodule

bind lcdreg_top lcdreg_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .addr            (addr),
    .wdata           (wdata),
    .ev_frame_done   (ev_frame_done),
    .ev_palette_done (ev_palette_done),
    .ev_sync_error   (ev_sync_error),
    .irq             (irq),
    .update_req      (update_req),
    .enable_o        (enable_o),
    .width_m1        (width_m1),
    .flags           (flags_q)
);

// File: tb/test_lcdreg_top.sv
`timescale 1ns/1ps
module test_lcdreg_top;
    localparam int ADDR_W = 8;
    localparam int DIM_W  = 10;
    localparam int K_RD = 0, K_IRQ = 1, K_UPD = 2, K_WID = 3, K_HGT = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              ev_fd = 1'b0, ev_pd = 1'b0, ev_se = 1'b0;
    logic              irq, update_req, enable_o, tft_o, mono_o;
    logic [1:0]        pal_mode_o;
    logic [DIM_W-1:0]  width_m1, height_m1;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  rd_req = 1'b0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    lcdreg_top #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_lcdreg_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_frame_done(ev_fd), .ev_palette_done(ev_pd),
        .ev_sync_error(ev_se), .irq(irq), .update_req(update_req),
        .enable_o(enable_o), .pal_mode_o(pal_mode_o), .tft_o(tft_o),
        .mono_o(mono_o), .width_m1(width_m1), .height_m1(height_m1)
    );

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] obs;
        if (rd_req && q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                K_RD:    obs = rdata;
                K_IRQ:   obs = {31'b0, irq};
                K_UPD:   obs = {31'b0, update_req};
                K_WID:   obs = 32'(width_m1);
                default: obs = 32'(height_m1);
            endcase
            n_run++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic expect_v(input int kind, input logic [7:0] a,
                            input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        addr = a;
        q.push_back(it);
        rd_req = 1'b1;
        @(negedge clk);
        #1 rd_req = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic fd, input logic pd, input logic se);
        @(posedge clk); #1;
        ev_fd = fd; ev_pd = pd; ev_se = se;
        @(posedge clk); #1;
        ev_fd = 1'b0; ev_pd = 1'b0; ev_se = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R10 reset state
        expect_v(K_RD, 8'h00, 32'hFE00_0C34, "R10 ctrl reset");
        expect_v(K_RD, 8'h04, 32'h0000_000F, "R10 tim0 reset");
        expect_v(K_RD, 8'h0C, 32'hFC00_0000, "R10 tim2 reset");
        expect_v(K_RD, 8'h10, 32'h0, "R10 status reset");
        expect_v(K_WID, 8'h00, 32'h0, "R10 width reset");
        expect_v(K_IRQ, 8'h00, 32'h0, "R10 irq reset");
        // R2 and R8: all ones into control
        wr(8'h00, 32'hFFFF_FFFF);
        expect_v(K_UPD, 8'h00, 32'h1, "R8 pulse on enable rise");
        expect_v(K_RD, 8'h00, 32'hFFFF_FFBF, "R2 ctrl all ones");
        expect_v(K_UPD, 8'h00, 32'h0, "R8 pulse one cycle");
        wr(8'h00, 32'h0000_0001);
        expect_v(K_UPD, 8'h00, 32'h0, "R8 no pulse same enable");
        expect_v(K_RD, 8'h00, 32'hFE00_0C35, "R2 ctrl enable only");
        wr(8'h00, 32'h0000_0089);
        expect_v(K_RD, 8'h00, 32'hFE80_0CBD, "R2 ctrl tft dup");
        // R3 / R4 / R5 timing and subpanel
        wr(8'h04, 32'h1234_5678);
        expect_v(K_RD, 8'h04, 32'h1234_567F, "R3 tim0 readback");
        expect_v(K_WID, 8'h00, 32'h278, "R3 width field");
        wr(8'h04, 32'h0000_03FF);
        expect_v(K_WID, 8'h00, 32'h3FF, "R3 width max");
        wr(8'h08, 32'hABCD_E000);
        expect_v(K_RD, 8'h08, 32'hABCD_E000, "R4 tim1 readback");
        expect_v(K_HGT, 8'h00, 32'h0, "R4 height zero");
        wr(8'h08, 32'h0000_0155);
        expect_v(K_HGT, 8'h00, 32'h155, "R4 height field");
        wr(8'h0C, 32'h0123_4567);
        expect_v(K_RD, 8'h0C, 32'hFD23_4567, "R4 tim2 readback");
        wr(8'h14, 32'hFFFF_FFFF);
        expect_v(K_RD, 8'h14, 32'hA1FF_FFFF, "R5 subpanel mask");
        // R1 unmapped
        expect_v(K_RD, 8'h18, 32'h0, "R1 unmapped 0x18");
        expect_v(K_RD, 8'h02, 32'h0, "R1 misaligned");
        wr(8'h18, 32'h0);
        expect_v(K_RD, 8'h14, 32'hA1FF_FFFF, "R1 unmapped write inert");
        // R6 / R7 events, frame enable on
        pulse(1, 0, 0);
        expect_v(K_RD, 8'h10, 32'h1, "R6 frame flag");
        expect_v(K_IRQ, 8'h00, 32'h1, "R7 frame irq");
        pulse(0, 1, 0);
        expect_v(K_RD, 8'h10, 32'h41, "R6 palette flag");
        wr(8'h00, 32'h0);
        expect_v(K_UPD, 8'h00, 32'h1, "R8 pulse on enable fall");
        expect_v(K_RD, 8'h10, 32'h0, "R9 clear on disable");
        expect_v(K_IRQ, 8'h00, 32'h0, "R7 irq low after clear");
        wr(8'h00, 32'h11);
        pulse(1, 0, 0);
        expect_v(K_IRQ, 8'h00, 32'h0, "R7 frame masked");
        pulse(0, 0, 1);
        expect_v(K_RD, 8'h10, 32'h5, "R6 sync flag");
        expect_v(K_IRQ, 8'h00, 32'h1, "R7 sync unmasked");
        wr(8'h10, 32'hFFFF_FFFF);
        expect_v(K_RD, 8'h10, 32'h5, "R6 status write inert");
        // R9 collision: disable write with palette event on same edge
        @(posedge clk); #1;
        wr_en = 1'b1; addr = 8'h00; wdata = 32'h0; ev_pd = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; ev_pd = 1'b0;
        expect_v(K_UPD, 8'h00, 32'h1, "R9 collision pulse");
        expect_v(K_RD, 8'h10, 32'h40, "R9 event wins over clear");
        expect_v(K_IRQ, 8'h00, 32'h0, "R7 palette masked");
        pulse(1, 0, 0);
        wr(8'h00, 32'h0);
        expect_v(K_RD, 8'h10, 32'h41, "R9 no clear when already off");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule